// File: doc/BRIEF.md
# Sampling Converter Result Port and Abort Sequencer

This block is the digital side of a 16-bit sampling converter that presents its result on a parallel port. It sequences the converter through a start-up delay, an acquisition phase, a conversion phase and, when needed, a wait for chip-select. It also holds the most recent result in an output latch. A falling edge on the convert-start input during acquisition begins a conversion, and `busy` stays high while it runs. When the conversion completes, the code on `sample_code` (the stand-in for the analog front end) is latched unchanged as a straight-binary result.

The host reads the latch over a 16-bit port. The port is enabled only while both chip-select and read are low, and it is modelled as a data vector plus an output enable, so no internal tri-state is needed. A byte-select input lets an 8-bit host read both halves of the result through the upper eight lines.

A conversion in progress is aborted by the external asynchronous reset or by two illegal events while busy: a convert-start falling edge with chip-select low, or a chip-select falling edge. An abort clears the latch and restarts the start-up delay. All inputs are assumed synchronous to `clk`.

Top module: `sar_readout_ctrl`

## Requirements
- R1: `bus_oe` is 1 exactly when `cs_n` and `rd_n` are both 0. Otherwise `bus_oe` is 0 and `bus_out` is 16'h0000.
- R2: With `byte_sel` = 0 and the port enabled, `bus_out` equals the 16-bit latched result, bit for bit.
- R3: With `byte_sel` = 1 and the port enabled, `bus_out[15:8]` carries result bits 7..0 and `bus_out[7:0]` reads 8'hFF.
- R4: While `rst_n` is 0, independent of `cs_n`, `busy` and `acq` are 0 and the latched result is 16'h0000.
- R5: After `rst_n` rises, `acq` rises after ceil(START_DELAY_NS / CLK_PERIOD_NS) rising clock edges, which is 2 at the defaults.
- R6: A `convst_n` falling edge while `acq` is 1 raises `busy` for exactly CONV_CYCLES clock cycles (8 at the defaults). On the edge where `busy` falls, `sample_code` is loaded into the latch.
- R7: When `busy` falls at the end of a conversion, `acq` rises on the same edge if `cs_n` is 0. If `cs_n` is 1, `acq` stays 0 until the next `cs_n` falling edge.
- R8: A `convst_n` falling edge while `busy` is 1 and `cs_n` is 0 aborts the conversion. On the next edge `busy` is 0 and the latch is 16'h0000, and `acq` then follows the R5 start-up delay.
- R9: A `cs_n` falling edge while `busy` is 1 aborts the conversion in the same way as R8.
- R10: A `convst_n` falling edge while `cs_n` is 1 during a conversion has no effect. A `convst_n` falling edge while `acq` is 0 and `busy` is 0 also has no effect. A `cs_n` falling edge during acquisition has no effect.
- R11: The result is straight binary: codes 16'h0000, 16'h7FFF, 16'h8000 and 16'hFFFF read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts and clears |
| convst_n | input | 1 | Convert start, falling-edge active |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| byte_sel | input | 1 | 1 moves result low byte to the upper bus lines |
| sample_code | input | 16 | Front-end code latched at the end of a conversion |
| bus_out | output | 16 | Parallel port data (0 when not enabled) |
| bus_oe | output | 1 | Parallel port output enable |
| busy | output | 1 | Conversion in progress |
| acq | output | 1 | Acquisition phase; a convert start is accepted |

## Verification
Conversions are run with the codes zero, midscale, midscale minus one, full scale and an alternating pattern. The extreme codes show that no recoding takes place. The alternating pattern, read with both byte-select values, tells a correct lane swap apart from a plain shift or a missing all-ones fill. Aborts are triggered once by a second convert start with chip-select low and once by a chip-select falling edge, each after a nonzero result, so that a clear that never happens is visible. A convert start with chip-select high during a conversion, which must be ignored, separates an over-eager abort from correct behaviour. Ending that conversion with chip-select high then shows whether acquisition correctly waits for the next chip-select edge.

// File: rtl/sar_readout_pkg.sv
package sar_readout_pkg;

  localparam int unsigned RES_W  = 16;
  localparam int unsigned HALF_W = RES_W / 2;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_ACQ   = 2'd1,
    ST_CONV  = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_t;

  // Whole clock cycles needed to cover a delay in ns (at least one).
  function automatic int unsigned cycles_for(input int unsigned delay_ns,
                                             input int unsigned period_ns);
    int unsigned c;
    c = (delay_ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

  // Port lane arrangement: upper_only moves the low half up, fills low lines with ones.
  function automatic logic [RES_W-1:0] lane_select(input logic [RES_W-1:0] res,
                                                   input logic upper_only);
    logic [RES_W-1:0] v;
    if (upper_only) v = {res[HALF_W-1:0], {HALF_W{1'b1}}};
    else            v = res;
    return v;
  endfunction

endpackage

// File: rtl/sar_edge_detect.sv
module sar_edge_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_n,
  output logic [N-1:0] fell
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lines_n;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign fell[i] = prev_q[i] & ~lines_n[i];
  end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_readout_pkg::*;
#(
  parameter int unsigned START_CYC = 2,
  parameter int unsigned CONV_CYC  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             convst_fell,
  input  logic             cs_fell,
  input  logic             cs_n,
  input  logic [RES_W-1:0] sample_code,
  output logic             busy,
  output logic             acq,
  output logic [RES_W-1:0] result
);

  localparam int unsigned MAX_CYC = (START_CYC > CONV_CYC) ? START_CYC : CONV_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CYC - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] result_q;

  // Named internal events
  logic abort_evt;
  logic conv_done;
  logic conv_start;

  assign abort_evt  = (state_q == ST_CONV) && (cs_fell || (convst_fell && !cs_n));
  assign conv_done  = (state_q == ST_CONV) && (cnt_q == CONV_LAST) && !abort_evt;
  assign conv_start = (state_q == ST_ACQ) && convst_fell;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_START;
      cnt_q    <= '0;
      result_q <= '0;
    end else begin
      unique case (state_q)
        ST_START: begin
          if (cnt_q == START_LAST) begin
            state_q <= ST_ACQ;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ACQ: begin
          if (conv_start) begin
            state_q <= ST_CONV;
            cnt_q   <= '0;
          end
        end
        ST_CONV: begin
          if (abort_evt) begin
            state_q  <= ST_START;
            cnt_q    <= '0;
            result_q <= '0;
          end else if (conv_done) begin
            result_q <= sample_code;
            state_q  <= cs_n ? ST_HOLD : ST_ACQ;
            cnt_q    <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (cs_fell) state_q <= ST_ACQ;
        end
        default: state_q <= ST_START;
      endcase
    end
  end

  assign busy   = (state_q == ST_CONV);
  assign acq    = (state_q == ST_ACQ);
  assign result = result_q;

  // R8 R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && result == '0));

  // R6
  done_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (!busy && result == $past(sample_code)));

  // R10
  cs_high_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && convst_fell && cs_n && !cs_fell && !conv_done) |=> busy);

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> busy);

  // R5 R7
  acq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq) |-> ($past(state_q) != ST_CONV || !$past(cs_n)));

endmodule

// File: rtl/sar_bus_mux.sv
module sar_bus_mux
  import sar_readout_pkg::*;
(
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             byte_sel,
  input  logic [RES_W-1:0] result,
  output logic [RES_W-1:0] bus_out,
  output logic             bus_oe
);

  always_comb begin
    bus_oe  = ~cs_n & ~rd_n;
    bus_out = bus_oe ? lane_select(result, byte_sel) : '0;
  end

endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_readout_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS  = 10,
  parameter int unsigned START_DELAY_NS = 20,
  parameter int unsigned CONV_CYCLES    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             convst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             byte_sel,
  input  logic [RES_W-1:0] sample_code,
  output logic [RES_W-1:0] bus_out,
  output logic             bus_oe,
  output logic             busy,
  output logic             acq
);

  localparam int unsigned START_CYC = cycles_for(START_DELAY_NS, CLK_PERIOD_NS);

  logic [1:0]       fell;
  logic             convst_fell;
  logic             cs_fell;
  logic [RES_W-1:0] result;

  sar_edge_detect #(.N(2)) u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_n ({cs_n, convst_n}),
    .fell    (fell)
  );

  assign convst_fell = fell[0];
  assign cs_fell     = fell[1];

  sar_conv_seq #(
    .START_CYC (START_CYC),
    .CONV_CYC  (CONV_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .convst_fell (convst_fell),
    .cs_fell     (cs_fell),
    .cs_n        (cs_n),
    .sample_code (sample_code),
    .busy        (busy),
    .acq         (acq),
    .result      (result)
  );

  sar_bus_mux u_mux (
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .byte_sel (byte_sel),
    .result   (result),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe)
  );

  // R1
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (!bus_oe && bus_out == '0));

  // R3
  low_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && byte_sel) |-> (bus_out[HALF_W-1:0] == '1));

  // R6 R10
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && acq));

endmodule

// File: tb/sim_sar_readout_ctrl.sv
module sim_sar_readout_ctrl;

  localparam int CONV = 8;

  logic        clk = 1'b0;
  logic        rst_n, convst_n, cs_n, rd_n, byte_sel;
  logic [15:0] sample_code;
  logic [15:0] bus_out;
  logic        bus_oe, busy, acq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  logic [15:0] sb[$];

  always #5 clk = ~clk;

  sar_readout_ctrl #(
    .CLK_PERIOD_NS(10), .START_DELAY_NS(20), .CONV_CYCLES(CONV)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .convst_n(convst_n), .cs_n(cs_n), .rd_n(rd_n),
    .byte_sel(byte_sel), .sample_code(sample_code), .bus_out(bus_out),
    .bus_oe(bus_oe), .busy(busy), .acq(acq)
  );

  // Bench's own view of the port lanes: low byte shifted up, ones below.
  function automatic logic [15:0] expect_port(input logic [15:0] v, input logic b);
    return b ? ((v << 8) | 16'h00FF) : v;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // Monitor: on each busy fall, compare the port against the queued item.
  logic busy_d = 1'b0;
  always begin
    @(posedge clk);
    #2;
    if (busy_d && !busy && sb.size() > 0) begin
      logic [15:0] e;
      e = expect_port(sb.pop_front(), byte_sel);
      check(bus_oe == 1'b1, "R1 scoreboard oe", 32'(bus_oe), 32'd1);
      check(bus_out == e, "R6 scoreboard result", 32'(bus_out), 32'(e));
    end
    busy_d = busy;
  end

  // Driver: one normal conversion with cs_n and rd_n low.
  task automatic run_conv(input logic [15:0] code, input logic bsel);
    sample_code = code;
    byte_sel    = bsel;
    convst_n    = 1'b0;
    sb.push_back(code);
    tick(1);
    check(busy == 1'b1, "R6 busy rises", 32'(busy), 32'd1);
    convst_n = 1'b1;
    tick(CONV - 1);
    check(busy == 1'b1, "R6 busy held", 32'(busy), 32'd1);
    tick(1);
    check(busy == 1'b0, "R6 busy falls", 32'(busy), 32'd0);
    check(acq == 1'b1, "R7 acq at busy fall with cs low", 32'(acq), 32'd1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; convst_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1;
    byte_sel = 1'b0; sample_code = 16'h0;
    tick(2);
    // R4: reset state
    check(busy == 1'b0 && acq == 1'b0, "R4 idle in reset", {busy, acq}, 0);
    check(bus_oe == 1'b0, "R1 disabled in reset", 32'(bus_oe), 0);
    cs_n = 1'b0; rd_n = 1'b0; #1;
    check(bus_out == 16'h0000 && bus_oe, "R4 latch cleared", 32'(bus_out), 0);
    cs_n = 1'b1; rd_n = 1'b1;
    tick(1);
    rst_n = 1'b1;
    tick(1);
    check(acq == 1'b0, "R5 acq after one edge", 32'(acq), 0);
    tick(1);
    check(acq == 1'b1, "R5 acq after start delay", 32'(acq), 1);

    cs_n = 1'b0; rd_n = 1'b0;
    tick(1);
    check(acq == 1'b1 && busy == 1'b0, "R10 cs fall in acq ignored", {busy, acq}, 1);

    // R11 straight binary codes
    run_conv(16'h8000, 1'b0);
    run_conv(16'hFFFF, 1'b0);
    run_conv(16'h0000, 1'b0);
    run_conv(16'hA55A, 1'b1);   // R3 through the scoreboard
    byte_sel = 1'b0; #1;
    check(bus_out == 16'hA55A, "R2 full word", 32'(bus_out), 32'hA55A);
    byte_sel = 1'b1; #1;
    check(bus_out == 16'h5AFF, "R3 upper lanes", 32'(bus_out), 32'h5AFF);
    byte_sel = 1'b0;
    rd_n = 1'b1; #1;
    check(!bus_oe && bus_out == 16'h0, "R1 rd high", {bus_oe, bus_out}, 0);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    check(!bus_oe && bus_out == 16'h0, "R1 cs high", {bus_oe, bus_out}, 0);
    rd_n = 1'b1; #1;
    check(!bus_oe && bus_out == 16'h0, "R1 both high", {bus_oe, bus_out}, 0);
    tick(1);
    cs_n = 1'b0; rd_n = 1'b0;
    tick(1);
    check(acq == 1'b1, "R10 cs fall in acq keeps acq", 32'(acq), 1);
    run_conv(16'h7FFF, 1'b0);   // R11

    // R8: second convst with cs low aborts
    sample_code = 16'h1234; convst_n = 1'b0; sb.push_back(16'h0000);
    tick(1); convst_n = 1'b1;
    tick(2); convst_n = 1'b0;
    tick(1);
    check(busy == 1'b0 && acq == 1'b0, "R8 abort stops", {busy, acq}, 0);
    check(bus_out == 16'h0000, "R8 latch cleared", 32'(bus_out), 0);
    convst_n = 1'b1;
    tick(1);
    check(acq == 1'b0, "R8 restart delay", 32'(acq), 0);
    tick(1);
    check(acq == 1'b1, "R8 acq after restart", 32'(acq), 1);

    run_conv(16'h0F0F, 1'b0);

    // R9: cs falling edge aborts
    cs_n = 1'b1;
    tick(1);
    convst_n = 1'b0; sb.push_back(16'h0000);
    tick(1); convst_n = 1'b1;
    check(busy == 1'b1, "R6 start with cs high", 32'(busy), 1);
    tick(2); cs_n = 1'b0;
    tick(1);
    check(busy == 1'b0, "R9 abort on cs fall", 32'(busy), 0);
    check(bus_out == 16'h0000, "R9 latch cleared", 32'(bus_out), 0);
    tick(2);
    check(acq == 1'b1, "R9 acq after restart", 32'(acq), 1);

    // R10: convst with cs high is ignored; R7 wait for cs
    cs_n = 1'b1;
    tick(1);
    sample_code = 16'hC3C3; convst_n = 1'b0;
    tick(1); convst_n = 1'b1;
    tick(2); convst_n = 1'b0;
    tick(1);
    check(busy == 1'b1, "R10 convst with cs high ignored", 32'(busy), 1);
    convst_n = 1'b1;
    tick(4);
    check(busy == 1'b1, "R10 conversion length kept", 32'(busy), 1);
    tick(1);
    check(busy == 1'b0 && acq == 1'b0, "R7 waits for cs", {busy, acq}, 0);
    convst_n = 1'b0;
    tick(1); convst_n = 1'b1;
    check(busy == 1'b0 && acq == 1'b0, "R10 convst while waiting", {busy, acq}, 0);
    tick(1);
    cs_n = 1'b0;
    tick(1);
    check(acq == 1'b1, "R7 acq on cs fall", 32'(acq), 1);
    #1;
    check(bus_out == 16'hC3C3, "R6 result loaded", 32'(bus_out), 32'hC3C3);

    tick(2);
    check(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);
    finished = 1'b1;
    report();
  end

endmodule